// File: doc/BRIEF.md
# SPI Slave Byte Engine with Underrun Padding

This block is an SPI slave for mode 0 transfers of 8-bit characters, sent most significant bit first. It runs on a fast system clock. The serial clock, the data input and the active-low select each pass through a two-flop synchroniser. An edge detector follows the synchronisers, and the slave acts on the edges it reports. Each character the master shifts in is stored in a receive FIFO. Each completed character also makes the slave load its next outgoing character. That character comes from a transmit FIFO, which local logic fills through a simple write strobe.

When the transmit FIFO is empty at the moment a character is needed, the slave sends a filler byte instead and raises an underrun event. A configuration input chooses the filler: either the last byte that was loaded, or the all-ones busy token. The same input chooses the padding byte. Inside a select window, once a character has been received, every write into an empty transmit FIFO puts one padding byte ahead of the new data. This gives the serialiser time to fetch the data. Status outputs report receive-data-available, transmit-space-free and transmit-idle. Receive overflow and transmit underrun each have a one-cycle event pulse and a sticky flag that a clear strobe resets.

Top module: `spi_pad_slave`

## Requirements
- R1: While selected, the slave samples `mosiIn` on each rising `sckIn` edge, MSB first. After 8 samples it pushes the character into the receive FIFO. `rxValid` is 1 while that FIFO holds data. `rxData` shows the oldest entry, and `rxRead` removes it. A read from an empty FIFO has no effect.
- R2: If the receive FIFO is full before the cycle in which a character completes, the character is dropped. `ovfEvt` pulses for one cycle and `ovfFlag` goes to 1 and stays there.
- R3: `misoOut` always shows the MSB of the byte in the serialiser. On each falling `sckIn` edge inside a character, the next bit moves to `misoOut`. A new byte is loaded when select asserts and when a character completes. A pin change reaches the outputs on the third rising clock edge after it.
- R4: A load that finds the transmit FIFO empty, with no padding pending, sends a filler byte. It also pulses `undEvt` for one cycle and sets the sticky `undFlag`.
- R5: With `fillSel` = 0, the filler byte is the last byte loaded into the serialiser (all ones after reset). With `fillSel` = 1, the filler byte is 0xFF.
- R6: `txIdle` is 1 when all three of these hold: the transmit FIFO is empty, no padding byte is pending, and the last data or padding byte loaded has completed or been abandoned at deselect. A write into an idle engine clears `txIdle`.
- R7: `txFree` is 0 only while the transmit FIFO is full. A write while it is full is ignored.
- R8: The slave becomes armed once a character has been received in the current select window. While armed, an accepted write into an empty transmit FIFO makes the next load send one padding byte (value per R5) instead of FIFO data. That padding load raises no underrun. The written data follows in the load after it.
- R9: Deasserting select does three things. It resets the bit count, throwing away any partial character. It disarms padding and drops any pending padding byte. It marks the serialiser empty. While deselected, `sckIn` edges are ignored.
- R10: `ovfClr` and `undClr` clear their sticky flags. If a new event arrives in the same cycle as a clear, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the master (idle low) |
| mosiIn | input | 1 | Serial data from the master |
| selN | input | 1 | Active-low slave select |
| misoOut | output | 1 | Serial data to the master |
| fillSel | input | 1 | Filler/padding choice: 0 repeat last byte, 1 send 0xFF |
| txData | input | 8 | Byte to queue for transmission |
| txWrite | input | 1 | Write strobe for `txData` |
| rxRead | input | 1 | Pops the oldest received byte |
| rxData | output | 8 | Oldest received byte |
| ovfClr | input | 1 | Clears `ovfFlag` |
| undClr | input | 1 | Clears `undFlag` |
| rxValid | output | 1 | Receive FIFO not empty |
| txFree | output | 1 | Transmit FIFO not full |
| txIdle | output | 1 | No transmit data queued or in flight |
| ovfFlag | output | 1 | Sticky receive overflow |
| undFlag | output | 1 | Sticky transmit underrun |
| ovfEvt | output | 1 | One-cycle overflow pulse |
| undEvt | output | 1 | One-cycle underrun pulse |

## Verification
Two functions can land in the same cycle: the character-boundary load of the serialiser, and a local write into an empty transmit FIFO. When they coincide, the load sees the FIFO as it was before the write. It therefore sends a filler and raises an underrun. The write is accepted in that same cycle and arms the padding, so one padding byte goes out before the written data. The bench provokes this by timing `txWrite` to the clock edge that acts on the eighth rising SCK edge. A behavioural queue model resolves both events from the state before that cycle, and the bench checks the next three bytes seen on `misoOut`.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;

  // Per-cycle strobes sent from the control to the datapath
  typedef struct packed {
    logic rxShift;   // sample one input bit
    logic rxPush;    // store the completed character
    logic txShift;   // advance the output shifter
    logic txLoad;    // load a new byte into the output shifter
    logic loadFill;  // the loaded byte is filler/padding, not FIFO data
    logic txPop;     // remove the head of the transmit FIFO
    logic mosiBit;   // synchronised input bit
  } spiStrobeT;

endpackage

// File: rtl/spi_pad_fifo.sv
module spi_pad_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl
  import spi_pad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sckIn,
  input  logic      mosiIn,
  input  logic      selN,
  input  logic      txWrite,
  input  logic      rxFull,
  input  logic      txEmpty,
  input  logic      txFull,
  input  logic      ovfClr,
  input  logic      undClr,
  output spiStrobeT st,
  output logic      ovfEvt,
  output logic      undEvt,
  output logic      ovfFlag,
  output logic      undFlag,
  output logic      txIdle
);
  localparam int BCW = $clog2(DATA_W);

  logic [2:0]     sckS, selS;
  logic [1:0]     mosiS;
  logic           active, padArmed, padPending, serBusy;
  logic [BCW-1:0] bitCnt;
  logic sckRise, sckFall, selAssert, selRelease;
  logic rise, fall, charDone, load, loadPad, loadFifo, underrun, padTrig;

  // Synchronise, then detect edges between stages 1 and 2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      selS  <= '1;
      mosiS <= '0;
    end else begin
      sckS  <= {sckS[1:0], sckIn};
      selS  <= {selS[1:0], selN};
      mosiS <= {mosiS[0], mosiIn};
    end
  end

  assign sckRise    = sckS[1] & ~sckS[2];
  assign sckFall    = ~sckS[1] & sckS[2];
  assign selAssert  = ~selS[1] & selS[2];
  assign selRelease = selS[1] & ~selS[2];

  assign rise     = sckRise & active & ~selRelease;
  assign fall     = sckFall & active & ~selRelease;
  assign charDone = rise & (bitCnt == BCW'(DATA_W - 1));
  assign load     = selAssert | charDone;
  assign loadPad  = load & padPending;
  assign loadFifo = load & ~padPending & ~txEmpty;
  assign underrun = load & ~padPending & txEmpty;
  assign padTrig  = txWrite & ~txFull & txEmpty & padArmed & active & ~selRelease;

  always_comb begin
    st.rxShift  = rise;
    st.rxPush   = charDone & ~rxFull;
    st.txShift  = fall & (bitCnt != '0);
    st.txLoad   = load;
    st.loadFill = load & ~loadFifo;
    st.txPop    = loadFifo;
    st.mosiBit  = mosiS[1];
  end

  assign txIdle = txEmpty & ~serBusy & ~padPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      bitCnt     <= '0;
      padArmed   <= 1'b0;
      padPending <= 1'b0;
      serBusy    <= 1'b0;
      ovfEvt     <= 1'b0;
      undEvt     <= 1'b0;
      ovfFlag    <= 1'b0;
      undFlag    <= 1'b0;
    end else begin
      ovfEvt <= charDone & rxFull;
      undEvt <= underrun;
      if (charDone & rxFull) ovfFlag <= 1'b1;
      else if (ovfClr)       ovfFlag <= 1'b0;
      if (underrun)          undFlag <= 1'b1;
      else if (undClr)       undFlag <= 1'b0;

      if (selRelease) begin
        active     <= 1'b0;
        bitCnt     <= '0;
        padArmed   <= 1'b0;
        padPending <= 1'b0;
        serBusy    <= 1'b0;
      end else begin
        if (selAssert) begin
          active <= 1'b1;
          bitCnt <= '0;
        end else if (rise) begin
          bitCnt <= charDone ? '0 : bitCnt + BCW'(1);
        end
        if (charDone) padArmed <= 1'b1;
        if (padTrig)      padPending <= 1'b1;
        else if (loadPad) padPending <= 1'b0;
        if (load) serBusy <= loadPad | loadFifo;
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |-> ovfFlag);  // R2
  AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    undEvt |-> undFlag);  // R4
  AST_PAD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    padPending |-> (active && padArmed));  // R8
  AST_IDLE_BITCNT: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (bitCnt == '0));  // R9
endmodule

// File: rtl/spi_pad_dp.sv
module spi_pad_dp
  import spi_pad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         st,
  input  logic              fillSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              txFull,
  output logic              misoOut
);
  logic [DATA_W-1:0] rxSr, txSr, lastSent, txHead, fillByte, nextByte, rxWord;

  assign rxWord   = {rxSr[DATA_W-2:0], st.mosiBit};
  assign fillByte = fillSel ? '1 : lastSent;
  assign nextByte = st.loadFill ? fillByte : txHead;
  assign misoOut  = txSr[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr     <= '0;
      txSr     <= '1;
      lastSent <= '1;
    end else begin
      if (st.rxShift) rxSr <= rxWord;
      if (st.txLoad) begin
        txSr     <= nextByte;
        lastSent <= nextByte;
      end else if (st.txShift) begin
        txSr <= {txSr[DATA_W-2:0], 1'b0};
      end
    end
  end

  spi_pad_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(st.rxPush), .din(rxWord), .pop(rxRead),
    .dout(rxData), .empty(rxEmpty), .full(rxFull));

  spi_pad_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txWrite), .din(txData), .pop(st.txPop),
    .dout(txHead), .empty(txEmpty), .full(txFull));

  AST_RX_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    st.rxPush |-> !rxFull);  // R2
  AST_TX_POP_DATA: assert property (@(posedge clk) disable iff (!rstN)
    st.txPop |-> !txEmpty);  // R4
  AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    st.txLoad |=> (misoOut == $past(nextByte[DATA_W-1])));  // R3
endmodule

// File: rtl/spi_pad_slave.sv
module spi_pad_slave
  import spi_pad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selN,
  output logic              misoOut,
  input  logic              fillSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  input  logic              ovfClr,
  input  logic              undClr,
  output logic              rxValid,
  output logic              txFree,
  output logic              txIdle,
  output logic              ovfFlag,
  output logic              undFlag,
  output logic              ovfEvt,
  output logic              undEvt
);
  spiStrobeT st;
  logic rxEmpty, rxFull, txEmpty, txFull;

  spi_pad_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN),
    .txWrite(txWrite), .rxFull(rxFull), .txEmpty(txEmpty), .txFull(txFull),
    .ovfClr(ovfClr), .undClr(undClr), .st(st), .ovfEvt(ovfEvt), .undEvt(undEvt),
    .ovfFlag(ovfFlag), .undFlag(undFlag), .txIdle(txIdle));

  spi_pad_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .fillSel(fillSel), .txData(txData),
    .txWrite(txWrite), .rxRead(rxRead), .rxData(rxData), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .txEmpty(txEmpty), .txFull(txFull), .misoOut(misoOut));

  assign rxValid = ~rxEmpty;
  assign txFree  = ~txFull;

  AST_IDLE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txFree);  // R6
endmodule

// File: tb/test_spi_pad_slave.sv
`timescale 1ns/1ps
module test_spi_pad_slave;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, sckIn = 1'b0, mosiIn = 1'b0, selN = 1'b1, fillSel = 1'b0;
  logic [7:0] txData = '0, rxData;
  logic txWrite = 1'b0, rxRead = 1'b0, ovfClr = 1'b0, undClr = 1'b0;
  logic misoOut, rxValid, txFree, txIdle, ovfFlag, undFlag, ovfEvt, undEvt;

  spi_pad_slave i_spi_pad_slave (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN),
    .misoOut(misoOut), .fillSel(fillSel), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .rxData(rxData), .ovfClr(ovfClr), .undClr(undClr),
    .rxValid(rxValid), .txFree(txFree), .txIdle(txIdle), .ovfFlag(ovfFlag),
    .undFlag(undFlag), .ovfEvt(ovfEvt), .undEvt(undEvt));

  int vectors = 0, miscompares = 0, cycles = 0;

  // Behavioural reference model
  logic [7:0] rxQ[$], txQ[$];
  logic [7:0] curByte = 8'hFF, lastSent = 8'hFF, rxAcc = 8'h00;
  int bitCnt = 0, txIdx = 0;
  bit active = 0, padArmed = 0, padPending = 0, serBusy = 0;
  bit mOvf = 0, mUnd = 0, eOvf = 0, eUnd = 0;

  task automatic chk1(input string req, input string name, input logic [7:0] act,
                      input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, name, act, exp);
    end
  endtask

  task automatic compareAll();
    chk1("R1", "rxValid", rxValid, rxQ.size() > 0);
    if (rxQ.size() > 0) chk1("R1", "rxData", rxData, rxQ[0]);
    chk1("R2", "ovfFlag", ovfFlag, mOvf);
    chk1("R2", "ovfEvt", ovfEvt, eOvf);
    chk1("R4", "undFlag", undFlag, mUnd);
    chk1("R4", "undEvt", undEvt, eUnd);
    chk1("R3", "misoOut", misoOut, curByte[7 - txIdx]);
    chk1("R7", "txFree", txFree, txQ.size() < DEPTH);
    chk1("R6", "txIdle", txIdle, (txQ.size() == 0) && !serBusy && !padPending);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    eOvf = 0;
    eUnd = 0;
  endtask

  function automatic void mLoad();
    logic [7:0] b;
    if (padPending) begin
      b = fillSel ? 8'hFF : lastSent;
      padPending = 0;
      serBusy = 1;
    end else if (txQ.size() > 0) begin
      b = txQ.pop_front();
      serBusy = 1;
    end else begin
      b = fillSel ? 8'hFF : lastSent;
      serBusy = 0;
      eUnd = 1;
      mUnd = 1;
    end
    lastSent = b;
    curByte = b;
    txIdx = 0;
  endfunction

  task automatic wrTx(input logic [7:0] wd);
    txData = wd;
    txWrite = 1'b1;
    if (txQ.size() < DEPTH) begin
      if (txQ.size() == 0 && padArmed && active) padPending = 1;
      txQ.push_back(wd);
    end
    step();
    txWrite = 1'b0;
  endtask

  task automatic rdRx();
    rxRead = 1'b1;
    if (rxQ.size() > 0) void'(rxQ.pop_front());
    step();
    rxRead = 1'b0;
  endtask

  task automatic select(input bit on);
    selN = !on;
    step();
    step();
    if (on) begin
      active = 1;
      bitCnt = 0;
      mLoad();
    end else begin
      active = 0;
      bitCnt = 0;
      padArmed = 0;
      padPending = 0;
      serBusy = 0;
    end
    step();
  endtask

  // One SCK edge; the optional write lands on the edge that acts on it
  task automatic sckEdge(input bit rising, input bit doWr, input logic [7:0] wd);
    bit preEmpty, preArmed, preFull;
    sckIn = rising;
    step();
    step();
    preEmpty = (txQ.size() == 0);
    preArmed = padArmed;
    preFull  = (txQ.size() >= DEPTH);
    if (doWr) begin
      txData = wd;
      txWrite = 1'b1;
    end
    if (active) begin
      if (rising) begin
        rxAcc = {rxAcc[6:0], mosiIn};
        if (bitCnt == 7) begin
          bitCnt = 0;
          if (rxQ.size() < DEPTH) rxQ.push_back(rxAcc);
          else begin mOvf = 1; eOvf = 1; end
          padArmed = 1;
          mLoad();
        end else bitCnt++;
      end else if (bitCnt != 0) txIdx++;
    end
    if (doWr && !preFull) begin
      txQ.push_back(wd);
      if (preEmpty && preArmed && active) padPending = 1;
    end
    step();
    txWrite = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input bit wrAtEnd,
                          input logic [7:0] wd, output logic [7:0] got);
    got = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosiIn = b[i];
      step();
      got[i] = misoOut;
      sckEdge(1'b1, wrAtEnd && (i == 0), wd);
      sckEdge(1'b0, 1'b0, 8'h00);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit wrAtEnd, input logic [7:0] wd,
                          output logic [7:0] got);
    sendBits(b, 8, wrAtEnd, wd, got);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    step();
    step();
    rstN = 1'b1;
    step();
    chk1("R6", "reset txIdle", txIdle, 1);
    chk1("R1", "reset rxValid", rxValid, 0);

    // R3: queued data goes out in order
    wrTx(8'hA5);
    chk1("R6", "idle clears on write", txIdle, 0);
    wrTx(8'h3C);
    select(1'b1);
    sendByte(8'h5A, 0, 8'h00, got);
    chk1("R3", "first byte", got, 8'hA5);
    sendByte(8'hC3, 0, 8'h00, got);
    chk1("R3", "second byte", got, 8'h3C);
    // R5 repeat-last filler after underrun (R4)
    sendByte(8'h0F, 0, 8'h00, got);
    chk1("R5", "repeat filler", got, 8'h3C);
    chk1("R4", "underrun flag", undFlag, 1);
    fillSel = 1'b1;
    sendByte(8'hF0, 0, 8'h00, got);
    chk1("R5", "repeat filler again", got, 8'h3C);
    // R2: fifth character overflows the 4-entry FIFO
    sendByte(8'h11, 0, 8'h00, got);
    chk1("R5", "busy token", got, 8'hFF);
    chk1("R2", "overflow flag", ovfFlag, 1);
    chk1("R1", "oldest kept", rxData, 8'h5A);
    rdRx();

    // R8: write into empty FIFO while armed inserts a padding byte
    fillSel = 1'b0;
    wrTx(8'h77);
    sendByte(8'h22, 0, 8'h00, got);
    chk1("R8", "filler before pad", got, 8'hFF);
    sendByte(8'h33, 0, 8'h00, got);
    chk1("R8", "pad byte", got, 8'hFF);
    sendByte(8'h44, 0, 8'h00, got);
    chk1("R8", "data after pad", got, 8'h77);
    while (rxQ.size() > 0) rdRx();

    // Same cycle: write into empty FIFO at a character boundary
    sendByte(8'h55, 1, 8'h99, got);
    chk1("R4", "underrun filler at boundary", got, 8'h77);
    fillSel = 1'b1;
    sendByte(8'h66, 0, 8'h00, got);
    chk1("R4", "filler loaded with the write", got, 8'h77);
    sendByte(8'h67, 0, 8'h00, got);
    chk1("R8", "pad after boundary write", got, 8'hFF);
    sendByte(8'h68, 0, 8'h00, got);
    chk1("R8", "boundary-written data", got, 8'h99);
    while (rxQ.size() > 0) rdRx();

    // R9: partial character dropped on deselect, SCK ignored while deselected
    sendBits(8'hE0, 3, 0, 8'h00, got);
    select(1'b0);
    chk1("R6", "idle after deselect", txIdle, 1);
    sckEdge(1'b1, 0, 8'h00);
    sckEdge(1'b0, 0, 8'h00);
    chk1("R9", "no capture while deselected", rxValid, 0);
    wrTx(8'hAB);
    select(1'b1);
    sendByte(8'h81, 0, 8'h00, got);
    chk1("R9", "no pad without a received char", got, 8'hAB);
    chk1("R9", "clean character after reselect", rxData, 8'h81);
    rdRx();
    select(1'b0);

    // R10: sticky flags clear on strobe
    ovfClr = 1'b1;
    undClr = 1'b1;
    mOvf = 0;
    mUnd = 0;
    step();
    ovfClr = 1'b0;
    undClr = 1'b0;
    chk1("R10", "ovf cleared", ovfFlag, 0);
    chk1("R10", "und cleared", undFlag, 0);

    // R7: write while full is ignored
    wrTx(8'h01); wrTx(8'h02); wrTx(8'h03); wrTx(8'h04);
    chk1("R7", "full", txFree, 0);
    wrTx(8'hEE);
    select(1'b1);
    chk1("R7", "free after load", txFree, 1);
    sendByte(8'h10, 0, 8'h00, got); chk1("R7", "b1", got, 8'h01);
    sendByte(8'h20, 0, 8'h00, got); chk1("R7", "b2", got, 8'h02);
    sendByte(8'h30, 0, 8'h00, got); chk1("R7", "b3", got, 8'h03);
    sendByte(8'h40, 0, 8'h00, got); chk1("R7", "b4", got, 8'h04);
    sendByte(8'h50, 0, 8'h00, got); chk1("R7", "dropped write", got, 8'hFF);
    select(1'b0);
    chk1("R6", "final idle", txIdle, 1);

    summary();
    $finish;
  end
endmodule